// File: doc/BRIEF.md
# Interval Timer Channel (One-Shot Countdown)

This block is one channel of a programmable interval timer. A 16-bit down-counter is advanced by a clock-enable pulse that arrives at the fixed counting rate of 1,193,180 pulses per second. Software programs it through a byte-wide write port with three decoded addresses:

- a control address, where a control word selects a channel, an access mode, a counting mode and binary or decimal (BCD) counting;
- a data address, where the count is loaded;
- a status address, which holds a gate bit and a speaker-enable bit.

Only the one-shot mode is implemented. In that mode the OUT line is low while a count is in progress and rises when the count reaches zero. Software polls OUT through the status register and reads a low value as "still running". A typical use is a busy-wait delay. Software sets the gate, writes a control word for this channel, loads the count as a low byte followed by a high byte, and then waits for OUT to go high.

The channel number is a parameter. Control words aimed at another channel are ignored. So are read-back commands, latch commands and control words that select any mode other than the one-shot mode.

Top module: `pit_chan`

## Requirements
- R1: After reset, `out_o` is 1, `gate_o` and `spkr_o` are 0, and `status_o` reads 0x20.
- R2: A write to address 2 stores data bit 1 as the speaker enable and data bit 0 as the gate. `status_o` shows OUT at bit 5, the speaker enable at bit 1 and the gate at bit 0, with every other bit 0. Writing bit 5 has no effect on OUT.
- R3: A control word is written to address 1. Bits 7:6 select the channel, bits 5:4 select the access mode (01 low byte, 10 high byte, 11 low then high), bits 3:1 select the counting mode and bit 0 selects BCD. A word is accepted when it names this channel, uses a non-zero access mode and selects mode 0. An accepted word drives OUT low, stops the counter and restarts the byte sequence at the low byte.
- R4: The following control words leave OUT, the running count and the programmed access and BCD settings unchanged: a word for another channel, a read-back word (bits 7:6 = 11), a latch word (bits 5:4 = 00), or a word with a mode other than 0.
- R5: In low-then-high access mode, the first data write (address 0) after the control word supplies the low byte. The second supplies the high byte and loads the count. Further pairs of writes reload the count without a new control word.
- R6: In low-only access, each data write loads the count with a high byte of 0. In high-only access, each data write loads the count with a low byte of 0.
- R7: Counting starts at the first tick after the load. With a loaded count N (N > 0), OUT stays low for N-1 gated ticks and rises on the Nth.
- R8: Ticks that arrive while the gate bit is 0 do not advance the count.
- R9: In binary mode, a loaded count of 0 takes 65,536 ticks to reach terminal count.
- R10: Once OUT is high it stays high while the counter wraps and keeps counting. A new count load drives OUT low and starts a fresh countdown.
- R11: With the BCD bit set, the count decrements as four decimal digits. A load of 0x0010 takes 10 ticks, and a load of 0 takes 10,000 ticks.
- R12: Data writes made before any control word has been accepted are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Counting-rate clock-enable pulse |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | 0 data, 1 control, 2 status, 3 unused |
| wr_data | input | 8 | Write data byte |
| out_o | output | 1 | OUT line of the channel |
| gate_o | output | 1 | Gate bit from the status register |
| spkr_o | output | 1 | Speaker-enable bit from the status register |
| status_o | output | 8 | Status register read value |

## Verification
The hardest corners to reach are the two long full-range countdowns, where a loaded zero stands for 65,536 binary ticks or 10,000 decimal ticks. The bench reaches both by holding `tick_en` high continuously. It samples OUT one tick before the expected terminal count and again on it.

A second difficult case is rejecting a control word in the middle of a count. Here the bench issues several rejected control words while a count is running. It then confirms that OUT rises exactly when the original count predicts, and that the next pair of byte writes still loads as a low/high pair.

// File: rtl/pit_pkg.sv
package pit_pkg;

   typedef enum logic [1:0] {
      ACC_LATCH = 2'b00,
      ACC_LO    = 2'b01,
      ACC_HI    = 2'b10,
      ACC_WORD  = 2'b11
   } acc_e;

   localparam logic [1:0] ADDR_DATA   = 2'd0;
   localparam logic [1:0] ADDR_CTRL   = 2'd1;
   localparam logic [1:0] ADDR_STATUS = 2'd2;

   localparam int STAT_OUT_BIT  = 5;
   localparam int STAT_SPKR_BIT = 1;
   localparam int STAT_GATE_BIT = 0;

endpackage

// File: rtl/pit_ctrl_dec.sv
module pit_ctrl_dec
   import pit_pkg::*;
#(
   parameter int CHANNEL_ID = 2,
   parameter int DATA_W     = 8
) (
   input  logic              ctrl_we,
   input  logic [DATA_W-1:0] cw,
   output logic              accept,
   output logic              reject,
   output acc_e              acc_new,
   output logic              bcd_new
);
   localparam logic [1:0] SEL_ME   = 2'(CHANNEL_ID);
   localparam logic [2:0] MODE_ONE = 3'd0;

   logic [1:0] sel_f;
   logic [2:0] mode_f;

   always_comb begin
      sel_f   = cw[7:6];
      acc_new = acc_e'(cw[5:4]);
      mode_f  = cw[3:1];
      bcd_new = cw[0];
      accept  = ctrl_we && (sel_f == SEL_ME) && (acc_new != ACC_LATCH)
                && (mode_f == MODE_ONE);
      reject  = ctrl_we && !accept;
   end

endmodule

// File: rtl/pit_load_seq.sv
module pit_load_seq
   import pit_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int CNT_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_acc,
   input  acc_e              acc_new,
   input  logic              data_we,
   input  logic [DATA_W-1:0] data,
   output logic              load_stb,
   output logic [CNT_W-1:0]  load_val
);
   logic              armed_q;
   acc_e              acc_q;
   logic              hi_phase_q;
   logic [DATA_W-1:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q    <= 1'b0;
         acc_q      <= ACC_WORD;
         hi_phase_q <= 1'b0;
         lo_q       <= '0;
      end else if (ctrl_acc) begin
         armed_q    <= 1'b1;
         acc_q      <= acc_new;
         hi_phase_q <= 1'b0;
      end else if (data_we && armed_q && acc_q == ACC_WORD) begin
         if (!hi_phase_q) begin
            lo_q       <= data;
            hi_phase_q <= 1'b1;
         end else begin
            hi_phase_q <= 1'b0;
         end
      end
   end

   always_comb begin
      load_stb = data_we && armed_q && !ctrl_acc
                 && ((acc_q != ACC_WORD) || hi_phase_q);
      unique case (acc_q)
         ACC_LO:  load_val = {{DATA_W{1'b0}}, data};
         ACC_HI:  load_val = {data, {DATA_W{1'b0}}};
         default: load_val = {data, lo_q};
      endcase
   end

   // R12: nothing loads before a control word has been accepted
   a_r12_no_load_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |-> !load_stb);

endmodule

// File: rtl/pit_down_cnt.sv
module pit_down_cnt #(
   parameter int CNT_W = 16,
   localparam int DIG  = CNT_W / 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             bcd,
   input  logic             step,
   output logic             term
);
   logic [CNT_W-1:0] cnt_q;
   logic             running_q;
   logic [CNT_W-1:0] bin_next;
   logic [CNT_W-1:0] bcd_next;
   logic [CNT_W-1:0] nxt;
   logic [DIG-1:0]   borrow;

   assign borrow[0] = 1'b1;

   for (genvar g = 0; g < DIG; g++) begin : g_digit
      logic [3:0] d;
      assign d = cnt_q[4*g +: 4];
      assign bcd_next[4*g +: 4] = borrow[g] ? ((d == 4'd0) ? 4'd9 : d - 4'd1) : d;
      if (g < DIG - 1) begin : g_chain
         assign borrow[g+1] = borrow[g] & (d == 4'd0);
      end
   end

   always_comb begin
      bin_next = cnt_q - 1'b1;
      nxt      = bcd ? bcd_next : bin_next;
      term     = step && running_q && !load && !stop && (nxt == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         running_q <= 1'b0;
      end else if (stop) begin
         running_q <= 1'b0;
      end else if (load) begin
         cnt_q     <= load_val;
         running_q <= 1'b1;
      end else if (step && running_q) begin
         cnt_q <= nxt;
      end
   end

   // R8: without a step, load or stop the count is frozen
   a_r8_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load && !stop) |=> $stable(cnt_q));

   // R10: a load always restarts the countdown
   a_r10_load_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !stop) |=> running_q);

endmodule

// File: rtl/pit_chan.sv
module pit_chan
   import pit_pkg::*;
#(
   parameter int CHANNEL_ID = 2,
   parameter int DATA_W     = 8,
   localparam int CNT_W     = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              out_o,
   output logic              gate_o,
   output logic              spkr_o,
   output logic [DATA_W-1:0] status_o
);
   if (CHANNEL_ID < 0 || CHANNEL_ID > 2) begin : g_bad_chan
      $error("pit_chan: CHANNEL_ID must be 0, 1 or 2");
   end
   if (DATA_W < 8 || (DATA_W % 4) != 0) begin : g_bad_width
      $error("pit_chan: DATA_W must be a multiple of 4 and at least 8");
   end

   logic             ctrl_we, data_we, stat_we;
   logic             ctrl_acc, ctrl_rej;
   acc_e             acc_new;
   logic             bcd_new;
   logic             bcd_q;
   logic             load_stb;
   logic [CNT_W-1:0] load_val;
   logic             term;
   logic             out_q, gate_q, spkr_q;

   always_comb begin
      ctrl_we = wr_en && (wr_addr == ADDR_CTRL);
      data_we = wr_en && (wr_addr == ADDR_DATA);
      stat_we = wr_en && (wr_addr == ADDR_STATUS);
   end

   pit_ctrl_dec #(.CHANNEL_ID(CHANNEL_ID), .DATA_W(DATA_W)) u_dec (
      .ctrl_we (ctrl_we),
      .cw      (wr_data),
      .accept  (ctrl_acc),
      .reject  (ctrl_rej),
      .acc_new (acc_new),
      .bcd_new (bcd_new)
   );

   pit_load_seq #(.DATA_W(DATA_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_acc (ctrl_acc),
      .acc_new  (acc_new),
      .data_we  (data_we),
      .data     (wr_data),
      .load_stb (load_stb),
      .load_val (load_val)
   );

   pit_down_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .stop     (ctrl_acc),
      .load     (load_stb),
      .load_val (load_val),
      .bcd      (bcd_q),
      .step     (tick_en && gate_q),
      .term     (term)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcd_q  <= 1'b0;
         out_q  <= 1'b1;
         gate_q <= 1'b0;
         spkr_q <= 1'b0;
      end else begin
         if (ctrl_acc) bcd_q <= bcd_new;
         if (ctrl_acc || load_stb) out_q <= 1'b0;
         else if (term)            out_q <= 1'b1;
         if (stat_we) begin
            gate_q <= wr_data[STAT_GATE_BIT];
            spkr_q <= wr_data[STAT_SPKR_BIT];
         end
      end
   end

   always_comb begin
      out_o    = out_q;
      gate_o   = gate_q;
      spkr_o   = spkr_q;
      status_o = '0;
      status_o[STAT_OUT_BIT]  = out_q;
      status_o[STAT_SPKR_BIT] = spkr_q;
      status_o[STAT_GATE_BIT] = gate_q;
   end

   // R3: an accepted control word drops OUT on the next cycle
   a_r3_ctrl_drops_out: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_acc |=> !out_o);

   // R4: a rejected control word keeps the programmed number format
   a_r4_reject_keeps_fmt: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rej |=> $stable(bcd_q));

   // R10: OUT stays high until a control word or a count load
   a_r10_out_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (out_o && !ctrl_acc && !load_stb) |=> out_o);

   // R7: OUT only rises on a terminal count
   a_r7_rise_on_term: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_o && !term) |=> !out_o);

endmodule

// File: tb/tb_pit_chan.sv
module tb_pit_chan;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       out_o, gate_o, spkr_o;
   logic [7:0] status_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   pit_chan dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .out_o(out_o),
      .gate_o(gate_o), .spkr_o(spkr_o), .status_o(status_o)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ticks(int n);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   // count of n: low after n-1 ticks, high after the nth
   task automatic run_expect(string tag, int n);
      ticks(n - 1);
      chk(tag, out_o, 1'b0);
      ticks(1);
      chk(tag, out_o, 1'b1);
   endtask

   task automatic t_reset;
      chk("R1 out", out_o, 1'b1);
      chk("R1 gate/spkr", {gate_o, spkr_o}, 2'b00);
      chk("R1 status", status_o, 8'h20);
   endtask

   task automatic t_status;
      wr(2'd2, 8'hFF);
      chk("R2 status all ones", status_o, 8'h23);
      chk("R2 pins", {gate_o, spkr_o}, 2'b11);
      wr(2'd2, 8'hDD);
      chk("R2 out read-only", status_o, 8'h21);
   endtask

   task automatic t_unarmed;
      wr(2'd0, 8'h05);
      wr(2'd0, 8'h00);
      ticks(8);
      chk("R12 data ignored", out_o, 1'b1);
   endtask

   task automatic t_word;
      wr(2'd1, 8'hB0);
      chk("R3 ctrl drops out", out_o, 1'b0);
      wr(2'd0, 8'h05);
      ticks(3);
      chk("R5 no start after low byte", out_o, 1'b0);
      wr(2'd0, 8'h00);
      run_expect("R5 R7 word count 5", 5);
      wr(2'd1, 8'hB0);
      wr(2'd0, 8'h33);
      wr(2'd1, 8'hB0);
      wr(2'd0, 8'h03);
      wr(2'd0, 8'h00);
      run_expect("R3 sequencer restart", 3);
   endtask

   task automatic t_single;
      wr(2'd1, 8'h90);
      wr(2'd0, 8'h07);
      run_expect("R6 low only", 7);
      wr(2'd1, 8'hA0);
      wr(2'd0, 8'h01);
      run_expect("R6 high only", 256);
   endtask

   task automatic t_gate;
      wr(2'd1, 8'hB0);
      wr(2'd0, 8'h04);
      wr(2'd0, 8'h00);
      ticks(2);
      wr(2'd2, 8'h00);
      ticks(10);
      chk("R8 gated off", out_o, 1'b0);
      wr(2'd2, 8'h01);
      run_expect("R8 resume", 2);
   endtask

   task automatic t_zero_and_wrap;
      wr(2'd1, 8'hB0);
      wr(2'd0, 8'h00);
      wr(2'd0, 8'h00);
      run_expect("R9 zero is 65536", 65536);
      ticks(100);
      chk("R10 sticky high", out_o, 1'b1);
      wr(2'd0, 8'h02);
      chk("R10 still high after low byte", out_o, 1'b1);
      wr(2'd0, 8'h00);
      chk("R10 reload drops out", out_o, 1'b0);
      run_expect("R10 reload count", 2);
   endtask

   task automatic t_reject;
      wr(2'd1, 8'hB0);
      wr(2'd0, 8'h06);
      wr(2'd0, 8'h00);
      ticks(2);
      wr(2'd1, 8'h30);
      wr(2'd1, 8'h70);
      wr(2'd1, 8'hF0);
      wr(2'd1, 8'hB2);
      wr(2'd1, 8'h80);
      wr(2'd1, 8'hB5);
      chk("R4 out kept", out_o, 1'b0);
      run_expect("R4 count undisturbed", 4);
      wr(2'd0, 8'h03);
      wr(2'd0, 8'h00);
      run_expect("R4 access kept", 3);
   endtask

   task automatic t_bcd;
      wr(2'd1, 8'hB1);
      wr(2'd0, 8'h10);
      wr(2'd0, 8'h00);
      run_expect("R11 bcd 10", 10);
      wr(2'd1, 8'hB1);
      wr(2'd0, 8'h00);
      wr(2'd0, 8'h00);
      run_expect("R11 bcd zero is 10000", 10000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_status;
      t_unarmed;
      t_word;
      t_single;
      t_gate;
      t_reject;
      t_bcd;
      t_zero_and_wrap;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule